// File: doc/BRIEF.md
# Quadrant-Based Torus Next-Hop Router

This block walks a packet across a three-dimensional torus network-on-chip one link at a time. The three dimensions may have different node counts. A start strobe captures the size of each dimension, the source coordinates and the destination coordinates. From the next cycle on, the block produces one neighbouring node per cycle, together with the link direction taken, until the destination is reached. It then pulses done and presents the number of links traversed.

Dimensions are resolved strictly one after another: first X, then Y, then Z. Within a dimension the block compares the signed offset to the destination against half the ring length. When the offset is larger than that half in either sign, the block uses the wrap-around link instead of travelling the long way. The resulting route is therefore minimal in every dimension, even when the sizes are unequal.

Top module: `torus_hop_router`

## Requirements
- R1: While idle, a high `start` at a clock edge captures sizes, source and destination, and `busy` is high after that edge. `start` and all route inputs are ignored while `busy` is high, so the route in progress keeps its original destination.
- R2: A Y hop is emitted only once the X coordinate equals the destination. A Z hop is emitted only once both X and Y are equal to the destination.
- R3: The offset in each dimension is destination minus current, taken as a signed value. If its magnitude is at most the dimension size divided by two (rounded down), the hop moves in the sign's direction. `hop_dir` is {axis, dec}, with axis 0 = X, 1 = Y, 2 = Z and dec = 1 for a decreasing coordinate, giving the codes 0 X+, 1 X-, 2 Y+, 3 Y-, 4 Z+ and 5 Z-.
- R4: If the offset exceeds half the size (rounded down) in either sign, the hop moves against the sign, toward the wrap-around edge. A coordinate that steps above size-1 becomes 0, and one that steps below 0 becomes size-1.
- R5: An offset whose magnitude equals exactly half of an even size goes in the direct direction, following its sign.
- R6: While a route is in progress, every cycle carries either one hop (`hop_valid` high with the new coordinates) or the done pulse. Each hop changes exactly one coordinate.
- R7: `done` pulses for one cycle, with `busy` falling at the same edge. `hop_count` then equals the sum over the three dimensions of min(|d|, size-|d|) and the number of hops emitted.
- R8: When source equals destination, `done` pulses one cycle after the start is accepted, with `hop_count` 0 and no hop emitted.
- R9: Sizes from 2 to 16 are accepted per dimension independently. A 5x6x3 route from (1,2,0) to (4,2,0) takes 2 hops. In a 4x4x8 torus starting at (3,3,1), the routes to (0,0,0), (0,0,4) and (0,0,5) take 3, 5 and 6 hops.
- R10: After reset, `busy`, `hop_valid` and `done` are low and `hop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a route; taken only while idle |
| size_x | input | 5 | Node count of the X ring, 2..16 |
| size_y | input | 5 | Node count of the Y ring, 2..16 |
| size_z | input | 5 | Node count of the Z ring, 2..16 |
| src_x | input | 4 | Source X coordinate |
| src_y | input | 4 | Source Y coordinate |
| src_z | input | 4 | Source Z coordinate |
| dst_x | input | 4 | Destination X coordinate |
| dst_y | input | 4 | Destination Y coordinate |
| dst_z | input | 4 | Destination Z coordinate |
| busy | output | 1 | Route in progress |
| hop_valid | output | 1 | Hop coordinates and direction are valid this cycle |
| hop_x | output | 4 | X coordinate after the hop |
| hop_y | output | 4 | Y coordinate after the hop |
| hop_z | output | 4 | Z coordinate after the hop |
| hop_dir | output | 3 | Link taken: {axis, dec} |
| done | output | 1 | One-cycle pulse at route completion |
| hop_count | output | 5 | Links traversed by the route just finished |

## Verification
Fixed sources are swept over every destination in the 4x4x8 and 5x6x3 tori. These sweeps separate direct hops from wrap hops on rings of odd and even length, and they include the exact-half ties that only even rings can produce. A full source-by-destination sweep of the 2x2x2 torus covers the smallest rings. There, every nonzero offset is a tie, and the wrap edge and the direct link reach the same node. Sparse sweeps of 16x16x16 and 3x7x2 tori exercise the widest coordinates and strongly unequal dimensions. Restarts issued in mid-route with different destinations show whether captured inputs can be disturbed. Every hop is compared against a shortest-ring-distance model, and the final count is compared against the closed-form minimum.

// File: rtl/torus_route_pkg.sv
// Shared definitions for the torus next-hop router.
// Assumes coordinates are unsigned and smaller than their ring size.
package torus_route_pkg;
    localparam int TR_COORD_W = 4;

    typedef enum logic [1:0] {
        AXIS_X = 2'd0,
        AXIS_Y = 2'd1,
        AXIS_Z = 2'd2
    } axis_e;

    // Direction code: axis in the upper bits, decreasing flag in bit 0.
    function automatic logic [2:0] dir_code(input axis_e axis, input logic dec);
        return {axis, dec};
    endfunction
endpackage

// File: rtl/torus_axis_step.sv
// One-dimension step decision for a ring of size_i nodes.
// Chooses the direct or wrap-around direction from the signed offset
// and half the ring size, then produces the neighbouring coordinate.
// Assumes 2 <= size_i <= 2**COORD_W and cur_i, dst_i < size_i.
module torus_axis_step #(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W:0]   size_i,
    input  logic [COORD_W-1:0] cur_i,
    input  logic [COORD_W-1:0] dst_i,
    output logic               moving_o,
    output logic               dec_o,
    output logic [COORD_W-1:0] next_o
);
    localparam int SIZE_W = COORD_W + 1;

    logic signed [COORD_W:0] offset;
    logic signed [COORD_W:0] half;
    logic [SIZE_W-1:0]       last;
    logic                    far;

    // Signed offset, half-ring threshold and the decision to go the other way round.
    always_comb begin
        offset   = $signed({1'b0, dst_i}) - $signed({1'b0, cur_i});
        half     = $signed({1'b0, size_i[SIZE_W-1:1]});
        last     = size_i - SIZE_W'(1);
        far      = (offset > half) || (offset < -half);
        moving_o = (offset != '0);
        dec_o    = far ? (offset > 0) : (offset < 0);
    end

    // Neighbour coordinate with modular wrap at both ring ends.
    always_comb begin
        if (dec_o) begin
            next_o = (cur_i == '0) ? last[COORD_W-1:0] : cur_i - COORD_W'(1);
        end else begin
            next_o = ({1'b0, cur_i} == last) ? '0 : cur_i + COORD_W'(1);
        end
    end
endmodule

// File: rtl/torus_axis_pick.sv
// Dimension-order selector: picks the lowest-numbered axis that still
// has a nonzero offset (X before Y before Z).
module torus_axis_pick
    import torus_route_pkg::*;
#(
    parameter int N_AXES = 3
) (
    input  logic [N_AXES-1:0] moving_i,
    output axis_e             axis_o,
    output logic              any_o
);
    // Fixed priority: the earliest unresolved dimension wins.
    always_comb begin
        any_o = |moving_i;
        if (moving_i[0])      axis_o = AXIS_X;
        else if (moving_i[1]) axis_o = AXIS_Y;
        else                  axis_o = AXIS_Z;
    end
endmodule

// File: rtl/torus_hop_router.sv
// Torus next-hop router. Captures ring sizes and endpoints on start,
// then emits one minimal-direction hop per cycle in X, Y, Z order and
// finishes with a done pulse carrying the hop count.
// Assumes sizes 2..2**COORD_W and coordinates inside their rings.
module torus_hop_router
    import torus_route_pkg::*;
#(
    parameter int COORD_W = TR_COORD_W
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start,
    input  logic [COORD_W:0]                        size_x,
    input  logic [COORD_W:0]                        size_y,
    input  logic [COORD_W:0]                        size_z,
    input  logic [COORD_W-1:0]                      src_x,
    input  logic [COORD_W-1:0]                      src_y,
    input  logic [COORD_W-1:0]                      src_z,
    input  logic [COORD_W-1:0]                      dst_x,
    input  logic [COORD_W-1:0]                      dst_y,
    input  logic [COORD_W-1:0]                      dst_z,
    output logic                                    busy,
    output logic                                    hop_valid,
    output logic [COORD_W-1:0]                      hop_x,
    output logic [COORD_W-1:0]                      hop_y,
    output logic [COORD_W-1:0]                      hop_z,
    output logic [2:0]                              hop_dir,
    output logic                                    done,
    output logic [$clog2(3*(1<<COORD_W)/2+1)-1:0]   hop_count
);
    localparam int N_AXES = 3;
    localparam int SIZE_W = COORD_W + 1;
    localparam int CNT_W  = $clog2(3 * (1 << COORD_W) / 2 + 1);

    logic [SIZE_W-1:0]  size_q [N_AXES];
    logic [COORD_W-1:0] cur_q  [N_AXES];
    logic [COORD_W-1:0] dst_q  [N_AXES];
    logic [CNT_W-1:0]   cnt_q;

    logic [N_AXES-1:0]  moving;
    logic [N_AXES-1:0]  dec_w;
    logic [COORD_W-1:0] next_w [N_AXES];
    axis_e              axis_sel;
    logic               any_move;
    logic               sel_dec;

    // One step decision per dimension.
    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        torus_axis_step #(.COORD_W(COORD_W)) u_step (
            .size_i  (size_q[a]),
            .cur_i   (cur_q[a]),
            .dst_i   (dst_q[a]),
            .moving_o(moving[a]),
            .dec_o   (dec_w[a]),
            .next_o  (next_w[a])
        );
    end

    torus_axis_pick #(.N_AXES(N_AXES)) u_pick (
        .moving_i(moving),
        .axis_o  (axis_sel),
        .any_o   (any_move)
    );

    // Direction flag of the selected dimension.
    always_comb begin
        case (axis_sel)
            AXIS_X:  sel_dec = dec_w[0];
            AXIS_Y:  sel_dec = dec_w[1];
            default: sel_dec = dec_w[2];
        endcase
    end

    // Route sequencer: capture on start, step one axis per cycle, finish with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            hop_valid <= 1'b0;
            done      <= 1'b0;
            hop_dir   <= '0;
            cnt_q     <= '0;
            for (int a = 0; a < N_AXES; a++) begin
                size_q[a] <= '0;
                cur_q[a]  <= '0;
                dst_q[a]  <= '0;
            end
        end else begin
            hop_valid <= 1'b0;
            done      <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy      <= 1'b1;
                    cnt_q     <= '0;
                    size_q[0] <= size_x;
                    size_q[1] <= size_y;
                    size_q[2] <= size_z;
                    cur_q[0]  <= src_x;
                    cur_q[1]  <= src_y;
                    cur_q[2]  <= src_z;
                    dst_q[0]  <= dst_x;
                    dst_q[1]  <= dst_y;
                    dst_q[2]  <= dst_z;
                end
            end else if (any_move) begin
                hop_valid <= 1'b1;
                hop_dir   <= dir_code(axis_sel, sel_dec);
                cnt_q     <= cnt_q + CNT_W'(1);
                for (int a = 0; a < N_AXES; a++) begin
                    if (axis_sel == axis_e'(a)) cur_q[a] <= next_w[a];
                end
            end else begin
                done <= 1'b1;
                busy <= 1'b0;
            end
        end
    end

    assign hop_x     = cur_q[0];
    assign hop_y     = cur_q[1];
    assign hop_z     = cur_q[2];
    assign hop_count = cnt_q;

    // Upper bound on a minimal route: the sum of the half-ring sizes.
    logic [CNT_W-1:0] min_bound;
    always_comb begin
        min_bound = CNT_W'(size_q[0] >> 1) + CNT_W'(size_q[1] >> 1) + CNT_W'(size_q[2] >> 1);
    end

    p_hold_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(dst_q[0]) && $stable(dst_q[1]) && $stable(dst_q[2])
                                   && $stable(size_q[0]) && $stable(size_q[1]) && $stable(size_q[2])))
        else $error("captured route inputs changed mid-route");

    p_y_after_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hop_valid && hop_dir[2:1] != 2'd0) |-> (cur_q[0] == dst_q[0]))
        else $error("Y/Z hop while X unresolved");

    p_z_after_y_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hop_valid && hop_dir[2:1] == 2'd2) |-> (cur_q[1] == dst_q[1]))
        else $error("Z hop while Y unresolved");

    p_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hop_valid |-> ({1'b0, hop_x} < size_q[0] && {1'b0, hop_y} < size_q[1]
                       && {1'b0, hop_z} < size_q[2]))
        else $error("hop left its ring");

    p_single_axis_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hop_valid && $past(busy)) |-> ($countones({cur_q[0] != $past(cur_q[0]),
                                                    cur_q[1] != $past(cur_q[1]),
                                                    cur_q[2] != $past(cur_q[2])}) == 1))
        else $error("hop changed other than one coordinate");

    p_done_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!hop_valid && !busy))
        else $error("done overlaps a hop or busy");

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hop_count <= min_bound))
        else $error("hop count above minimal bound");
endmodule

// File: tb/torus_hop_router_tb.sv
// Self-checking bench: sweeps destinations over several torus shapes and
// compares every hop and the final count with a shortest-ring model.
module torus_hop_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [CW:0]   size_x, size_y, size_z;
    logic [CW-1:0] src_x, src_y, src_z, dst_x, dst_y, dst_z;
    logic          busy, hop_valid, done;
    logic [CW-1:0] hop_x, hop_y, hop_z;
    logic [2:0]    hop_dir;
    logic [4:0]    hop_count;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    torus_hop_router #(.COORD_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .size_x(size_x), .size_y(size_y), .size_z(size_z),
        .src_x(src_x), .src_y(src_y), .src_z(src_z),
        .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
        .busy(busy), .hop_valid(hop_valid),
        .hop_x(hop_x), .hop_y(hop_y), .hop_z(hop_z),
        .hop_dir(hop_dir), .done(done), .hop_count(hop_count)
    );

    // Record one check; print a FAIL line on mismatch.
    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Shortest ring distance between two coordinates.
    function automatic int ring_min(input int sz, input int a, input int b);
        int f = (b - a + sz) % sz;
        return (f < sz - f) ? f : sz - f;
    endfunction

    // Model step on one ring: forward/backward modular distances, ties follow the raw sign.
    task automatic model_step(input int sz, input int c, input int d,
                              output int nxt, output bit dec, output string tag);
        int fwd = (d - c + sz) % sz;
        int bwd = sz - fwd;
        if (fwd < bwd)      begin dec = 1'b0; tag = (d > c) ? "R3" : "R4"; end
        else if (bwd < fwd) begin dec = 1'b1; tag = (d < c) ? "R3" : "R4"; end
        else                begin dec = (d < c); tag = "R5"; end
        nxt = dec ? (c + sz - 1) % sz : (c + 1) % sz;
    endtask

    // Run one route and check every cycle of it. poke: restart attempt mid-route.
    task automatic run_route(input int sx, input int sy, input int sz,
                             input int ax, input int ay, input int az,
                             input int bx, input int by, input int bz,
                             input int given, input bit poke);
        int  sizes[3];
        int  cur[3];
        int  dst[3];
        int  expect_total;
        int  steps = 0;
        bit  finished = 1'b0;
        sizes = '{sx, sy, sz};
        cur   = '{ax, ay, az};
        dst   = '{bx, by, bz};
        expect_total = ring_min(sx, ax, bx) + ring_min(sy, ay, by) + ring_min(sz, az, bz);
        @(negedge clk);
        while (busy) @(negedge clk);
        size_x = 5'(sx); size_y = 5'(sy); size_z = 5'(sz);
        src_x = 4'(ax); src_y = 4'(ay); src_z = 4'(az);
        dst_x = 4'(bx); dst_y = 4'(by); dst_z = 4'(bz);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1", "busy after accepted start", int'(busy), 1);
        if (poke) begin
            // R1: a restart with other endpoints while busy must be ignored.
            dst_x = 4'((bx + 1) % sx); dst_y = 4'((by + 1) % sy); dst_z = 4'((bz + 1) % sz);
            src_x = 4'(bx); size_x = 5'(sx == 16 ? 15 : sx + 1);
            start = 1'b1;
        end
        for (int cyc = 0; cyc < 64 && !finished; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (hop_valid) begin
                int    ax_i = (cur[0] != dst[0]) ? 0 : (cur[1] != dst[1]) ? 1 : 2;
                int    nxt;
                bit    dec;
                string tag;
                int    got[3];
                got = '{int'(hop_x), int'(hop_y), int'(hop_z)};
                model_step(sizes[ax_i], cur[ax_i], dst[ax_i], nxt, dec, tag);
                cur[ax_i] = nxt;
                steps++;
                chk(got[0] == cur[0] && got[1] == cur[1] && got[2] == cur[2], tag,
                    "hop coordinate (x*256+y*16+z)",
                    got[0] * 256 + got[1] * 16 + got[2], cur[0] * 256 + cur[1] * 16 + cur[2]);
                // R2: axis field must name the earliest unresolved dimension.
                chk(hop_dir == 3'(ax_i * 2 + int'(dec)), (int'(hop_dir[2:1]) != ax_i) ? "R2" : tag,
                    "hop direction code", int'(hop_dir), ax_i * 2 + int'(dec));
                chk(steps <= expect_total, "R7", "hops so far within minimum", steps, expect_total);
            end else if (done) begin
                finished = 1'b1;
                chk(int'(hop_count) == expect_total, "R7", "hop count vs ring minimum",
                    int'(hop_count), expect_total);
                chk(steps == expect_total, "R7", "hops emitted", steps, expect_total);
                chk(busy == 1'b0, "R7", "busy low with done", int'(busy), 0);
                if (expect_total == 0)
                    chk(cyc == 0, "R8", "zero-hop done latency (cycles)", cyc, 0);
                if (given >= 0)
                    chk(int'(hop_count) == given, "R9", "quoted route cost", int'(hop_count), given);
            end else begin
                chk(1'b0, "R6", "cycle with neither hop nor done", 0, 1);
            end
        end
        if (!finished) chk(1'b0, "R7", "route never finished", steps, expect_total);
        @(negedge clk);
        chk(done == 1'b0 && hop_valid == 1'b0, "R7", "done is a single pulse",
            int'(done), 0);
    endtask

    // Global watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 190000);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        size_x = 5'd4; size_y = 5'd4; size_z = 5'd4;
        src_x = '0; src_y = '0; src_z = '0;
        dst_x = '0; dst_y = '0; dst_z = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0 && hop_valid == 1'b0 && done == 1'b0, "R10", "control outputs in reset",
            int'({busy, hop_valid, done}), 0);
        chk(hop_count == '0, "R10", "hop count in reset", int'(hop_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R10", "idle after reset release", int'(busy), 0);

        // R9: quoted route costs in unequal tori
        run_route(5, 6, 3, 1, 2, 0, 4, 2, 0, 2, 1'b0);
        run_route(4, 4, 8, 3, 3, 1, 0, 0, 0, 3, 1'b0);
        run_route(4, 4, 8, 3, 3, 1, 0, 0, 4, 5, 1'b0);
        run_route(4, 4, 8, 3, 3, 1, 0, 0, 5, 6, 1'b0);

        // R8: source equals destination
        run_route(4, 4, 8, 3, 3, 1, 3, 3, 1, 0, 1'b0);
        run_route(16, 16, 16, 15, 0, 9, 15, 0, 9, 0, 1'b1);

        // R3 R4 R5: 4x4x8 from one source to every node
        for (int x = 0; x < 4; x++)
            for (int y = 0; y < 4; y++)
                for (int z = 0; z < 8; z++)
                    run_route(4, 4, 8, 3, 3, 1, x, y, z, -1, 1'b0);

        // R9: 5x6x3 from two sources to every node
        for (int x = 0; x < 5; x++)
            for (int y = 0; y < 6; y++)
                for (int z = 0; z < 3; z++) begin
                    run_route(5, 6, 3, 1, 2, 0, x, y, z, -1, 1'b0);
                    run_route(5, 6, 3, 4, 5, 2, x, y, z, -1, 1'b0);
                end

        // R5: smallest rings, every source to every destination
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 8; d++)
                run_route(2, 2, 2, s & 1, (s >> 1) & 1, s >> 2, d & 1, (d >> 1) & 1, d >> 2, -1, 1'b0);

        // R4: widest coordinates, wrap at both ends
        for (int x = 0; x < 5; x++)
            for (int y = 0; y < 5; y++)
                for (int z = 0; z < 5; z++) begin
                    int pts[5] = '{0, 7, 8, 9, 15};
                    run_route(16, 16, 16, 0, 15, 7, pts[x], pts[y], pts[z], -1, 1'b0);
                end

        // R9: strongly unequal 3x7x2
        for (int x = 0; x < 3; x++)
            for (int y = 0; y < 7; y++)
                for (int z = 0; z < 2; z++)
                    run_route(3, 7, 2, 2, 6, 1, x, y, z, -1, 1'b0);

        // R1: restart attempts mid-route must not disturb the route
        run_route(4, 4, 8, 3, 3, 1, 0, 0, 5, 6, 1'b1);
        run_route(5, 6, 3, 0, 0, 0, 3, 4, 2, -1, 1'b1);
        run_route(16, 16, 16, 1, 1, 1, 10, 9, 14, -1, 1'b1);

        finish_run();
    end
endmodule